// File: doc/BRIEF.md
# External Interrupt Trigger Unit

This block conditions a small set of asynchronous interrupt pins coming from outside the chip and turns each into a clean request line for an interrupt aggregator or a CPU interrupt input. Every pin is synchronised, then judged against a trigger type chosen by software: a rising edge, a falling edge, any edge, an active-high level or an active-low level. Edge events are held in a sticky latch until software acknowledges them. Level conditions are passed through without being latched.

Software reaches the configuration through two 32-bit registers with a simple write port and a combinational read port. Pins 0 to 3 live in the first register and pins 4 and 5 in the second. Inside a register, a pin's fields sit at the slot given by the pin number modulo 4. Each slot has an enable (mask) bit, a sense bit, a level-select bit, an any-edge bit and a write-only acknowledge bit. The pin count is a parameter and may be 0, 4 or 6.

Top module: `ext_irq_trigger`

## Requirements
- R1: After reset, every request output is 0. Every implemented pin is disabled and configured for active-low level triggering, so register 0 reads 0x0000_0F00 and register 1 reads 0x0000_0300 with six pins.
- R2: For pin slot s (pin modulo 4) in its register, the fields are: enable at bit s, sense at bit 4+s, level-select at bit 8+s, any-edge at bit 12+s and acknowledge at bit 16+s. The first four fields read back as written. Acknowledge bits, all other bits and the slots of unimplemented pins read 0.
- R3: Each pin passes through two synchronising flops. In a level mode, a change on a pin appears on its request after the second rising clock edge, and not after the first.
- R4: With any-edge 0, level-select 0 and sense 1, a 0-to-1 transition sets the pin's sticky latch. The request rises after the third rising clock edge following the pin change. A 1-to-0 transition sets nothing.
- R5: With any-edge 0, level-select 0 and sense 0, only a 1-to-0 transition sets the latch, with the same latency as R4.
- R6: With any-edge 1, both transitions set the latch, whatever the other two type bits hold.
- R7: With any-edge 0 and level-select 1, the request equals the synchronised pin when sense is 1 and its inverse when sense is 0. It is never latched.
- R8: A request is driven only while the pin's enable bit is 1. An edge that arrives while the pin is disabled is still latched and shows as soon as the pin is enabled.
- R9: Writing 1 to a pin's acknowledge bit clears that pin's latch on the same clock edge as the write. Writing 0 to it, or acknowledging another pin, leaves the latch unchanged.
- R10: When an acknowledge and a newly detected edge on the same pin fall in the same cycle, the latch stays set.
- R11: Pins 4 and 5 are configured through register 1, slots 0 and 1. Activity on one pin never changes another pin's request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | max(NUM_PINS,1) | Raw asynchronous interrupt pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select for writes (0: pins 0-3, 1: pins 4-5) |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 1 | Register select for reads |
| rd_data | output | 32 | Register read data (combinational) |
| irq_req | output | max(NUM_PINS,1) | Per-pin interrupt requests |

## Verification
The bench sweeps every pin through all eight combinations of the three type bits. At each step it drives a rise and a fall and predicts the request arithmetically from the bits. A decode that let level-select override any-edge, or that swapped the sense polarity, shows up as a wrong bit in that sweep. The latency checks one cycle early catch a missing or extra synchroniser stage. The same-cycle acknowledge-and-edge case targets a design that gives the acknowledge priority and so drops a real interrupt. The masked-edge case targets a design that gates the latch, rather than the output, with the enable bit. Full-vector comparisons catch a pin landing in the wrong register slot or disturbing a neighbour.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [2:0] {
    TRIG_LEVEL_LOW,
    TRIG_LEVEL_HIGH,
    TRIG_EDGE_FALL,
    TRIG_EDGE_RISE,
    TRIG_EDGE_ANY
  } trig_e;

  typedef struct packed {
    logic any_edge;
    logic level;
    logic sense;
    logic enable;
  } pin_cfg_t;

  localparam int SLOTS   = 4;
  localparam int F_EN    = 0;
  localparam int F_SENSE = 4;
  localparam int F_LEVEL = 8;
  localparam int F_ANY   = 12;
  localparam int F_ACK   = 16;

  localparam pin_cfg_t CFG_RESET = '{any_edge: 1'b0, level: 1'b1, sense: 1'b0, enable: 1'b0};

  function automatic trig_e decode_trig(pin_cfg_t c);
    if (c.any_edge)   return TRIG_EDGE_ANY;
    else if (c.level) return c.sense ? TRIG_LEVEL_HIGH : TRIG_LEVEL_LOW;
    else              return c.sense ? TRIG_EDGE_RISE : TRIG_EDGE_FALL;
  endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/ext_irq_cfg_regs.sv
module ext_irq_cfg_regs
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int PW       = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_addr,
  input  logic [31:0]     wr_data,
  input  logic            rd_addr,
  output logic [31:0]     rd_data,
  output pin_cfg_t        cfg_o [PW],
  output logic [PW-1:0]   ack_o
);

  for (genvar i = 0; i < PW; i++) begin : g_pin
    if (i < NUM_PINS) begin : g_impl
      localparam int REG_IDX = i / SLOTS;
      localparam int SLOT    = i % SLOTS;
      logic     sel;
      pin_cfg_t cfg_d, cfg_q;

      assign sel = wr_en && (int'(wr_addr) == REG_IDX);

      always_comb begin
        cfg_d.enable   = wr_data[F_EN + SLOT];
        cfg_d.sense    = wr_data[F_SENSE + SLOT];
        cfg_d.level    = wr_data[F_LEVEL + SLOT];
        cfg_d.any_edge = wr_data[F_ANY + SLOT];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cfg_q <= CFG_RESET;
        else if (sel) cfg_q <= cfg_d;
      end

      assign cfg_o[i] = cfg_q;
      assign ack_o[i] = sel & wr_data[F_ACK + SLOT];
    end else begin : g_none
      assign cfg_o[i] = '0;
      assign ack_o[i] = 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if ((i / SLOTS) == int'(rd_addr)) begin
        rd_data[F_EN + i % SLOTS]    = cfg_o[i].enable;
        rd_data[F_SENSE + i % SLOTS] = cfg_o[i].sense;
        rd_data[F_LEVEL + i % SLOTS] = cfg_o[i].level;
        rd_data[F_ANY + i % SLOTS]   = cfg_o[i].any_edge;
      end
    end
  end

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pin_s,
  input  pin_cfg_t cfg,
  input  logic     ack,
  output logic     req
);

  trig_e mode;
  logic  prev_q, latch_q, latch_d, latch_en;
  logic  edge_hit, is_edge_mode, level_val;

  assign mode = decode_trig(cfg);

  always_comb begin
    edge_hit     = 1'b0;
    is_edge_mode = 1'b1;
    level_val    = 1'b0;
    unique case (mode)
      TRIG_EDGE_RISE:  edge_hit = pin_s & ~prev_q;
      TRIG_EDGE_FALL:  edge_hit = ~pin_s & prev_q;
      TRIG_EDGE_ANY:   edge_hit = pin_s ^ prev_q;
      TRIG_LEVEL_HIGH: begin is_edge_mode = 1'b0; level_val = pin_s;  end
      TRIG_LEVEL_LOW:  begin is_edge_mode = 1'b0; level_val = ~pin_s; end
      default:         is_edge_mode = 1'b1;
    endcase
  end

  // acknowledge loses to a fresh edge in the same cycle
  always_comb begin
    latch_en = edge_hit | ack;
    latch_d  = edge_hit ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (latch_en) latch_q <= latch_d;
    end
  end

  assign req = cfg.enable & (is_edge_mode ? latch_q : level_val);

  // R10
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_edge_mode && (pin_s != prev_q) && (mode == TRIG_EDGE_ANY)) |=> latch_q);

  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !edge_hit) |=> !latch_q);

  // R7
  level_holds_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_edge_mode && !ack) |=> $stable(latch_q));

  // R4
  latch_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_q) |-> ($past(pin_s) != $past(prev_q)));

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.enable) |-> !req);

endmodule

// File: rtl/ext_irq_trigger.sv
module ext_irq_trigger
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS = 6,
  localparam int PW      = (NUM_PINS > 0) ? NUM_PINS : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pin_in,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          rd_addr,
  output logic [31:0]   rd_data,
  output logic [PW-1:0] irq_req
);

  logic [PW-1:0] pin_s;
  logic [PW-1:0] ack;
  pin_cfg_t      cfg [PW];

  ext_irq_sync #(.W(PW)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_s)
  );

  ext_irq_cfg_regs #(.NUM_PINS(NUM_PINS), .PW(PW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .cfg_o   (cfg),
    .ack_o   (ack)
  );

  for (genvar i = 0; i < PW; i++) begin : g_det
    if (i < NUM_PINS) begin : g_impl
      ext_irq_detect u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_s (pin_s[i]),
        .cfg   (cfg[i]),
        .ack   (ack[i]),
        .req   (irq_req[i])
      );
    end else begin : g_none
      assign irq_req[i] = 1'b0;
    end
  end

endmodule

// File: tb/tb_ext_irq_trigger.sv
module tb_ext_irq_trigger;

  localparam int CLK_PERIOD = 10;
  localparam int N = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  pin_in;
  logic          wr_en;
  logic          wr_addr;
  logic [31:0]   wr_data;
  logic          rd_addr;
  logic [31:0]   rd_data;
  logic [N-1:0]  irq_req;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_trigger #(.NUM_PINS(N)) dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_req(irq_req)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // slot fields: enable s, sense 4+s, level 8+s, any-edge 12+s, ack 16+s
  function automatic logic [31:0] slot_word(int s, logic [2:0] code, logic en, logic ack);
    logic [31:0] w;
    w = '0;
    w[s]      = en;
    w[4 + s]  = code[0];
    w[8 + s]  = code[1];
    w[12 + s] = code[2];
    w[16 + s] = ack;
    return w;
  endfunction

  function automatic logic [31:0] vec(int j, logic b);
    return b ? (32'd1 << j) : 32'd0;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin_in = '0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0; rd_addr = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    chk("R1 req", 32'(irq_req), 32'd0);
    rd_addr = 1'b0; #1; chk("R1 reg0", rd_data, 32'h0000_0F00);
    rd_addr = 1'b1; #1; chk("R1 reg1", rd_data, 32'h0000_0300);

    // R2 readback and R11 register split
    wr(1'b0, 32'hFFFF_FFFF);
    rd_addr = 1'b0; #1; chk("R2 reg0 readback", rd_data, 32'h0000_FFFF);
    wr(1'b1, 32'hFFFF_FFFF);
    rd_addr = 1'b1; #1; chk("R2 R11 reg1 readback", rd_data, 32'h0000_3333);
    wr(1'b1, 32'h0003_0000);
    rd_addr = 1'b1; #1; chk("R2 reg1 cleared", rd_data, 32'h0);
    wr(1'b0, 32'h000F_0000);
    rd_addr = 1'b0; #1; chk("R2 reg0 cleared", rd_data, 32'h0);

    // Sweep every pin through all eight type codes (R3..R7, R9, R11)
    for (int j = 0; j < N; j++) begin
      for (int c = 0; c < 8; c++) begin
        logic [2:0] code;
        logic any, lvl, sns;
        logic a;
        int s;
        code = 3'(c);
        any = code[2]; lvl = code[1]; sns = code[0];
        a = (j >= 4);
        s = j % 4;
        pin_in = '0;
        tick(4);
        wr(a, slot_word(s, code, 1'b1, 1'b1));
        chk("R7 R11 idle low", 32'(irq_req), vec(j, !any && lvl && !sns));
        pin_in[j] = 1'b1;
        tick(2);
        chk("R3 two-stage latency", 32'(irq_req), vec(j, !any && lvl && sns));
        tick(1);
        chk("R4 R6 R7 after rise", 32'(irq_req), vec(j, any || sns));
        wr(a, slot_word(s, code, 1'b1, 1'b1));
        chk("R9 after ack", 32'(irq_req), vec(j, !any && lvl && sns));
        pin_in[j] = 1'b0;
        tick(3);
        chk("R5 R6 R7 after fall", 32'(irq_req), vec(j, any || !sns));
        wr(a, slot_word(s, code, 1'b0, 1'b1));
      end
    end

    // R8: edge latched while disabled, visible once enabled
    pin_in = '0; tick(4);
    wr(1'b0, slot_word(0, 3'b001, 1'b0, 1'b1));
    pin_in[0] = 1'b1; tick(3);
    chk("R8 masked edge", 32'(irq_req), 32'd0);
    wr(1'b0, slot_word(0, 3'b001, 1'b1, 1'b0));
    chk("R8 R9 unmask shows latch, ack 0 keeps it", 32'(irq_req), 32'd1);

    // R9: ack of a different pin leaves pin 0 latched
    wr(1'b0, slot_word(0, 3'b001, 1'b1, 1'b0) | slot_word(1, 3'b001, 1'b0, 1'b1));
    chk("R9 other ack", 32'(irq_req), 32'd1);

    // R10: ack and new rising edge in the same cycle
    pin_in[0] = 1'b0; tick(3);
    pin_in[0] = 1'b1; tick(2);
    wr(1'b0, slot_word(0, 3'b001, 1'b1, 1'b1));
    chk("R10 edge beats ack", 32'(irq_req), 32'd1);
    wr(1'b0, slot_word(0, 3'b001, 1'b1, 1'b1));
    chk("R9 ack clears", 32'(irq_req), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule